// File: doc/BRIEF.md
# Address Bit-20 Wrap Gate with Reset Strap Capture

This block sits on the physical address path of a processor core. Its job is to reproduce the address wrap at the 1-Mbyte boundary that older real-mode software expects. It does this by forcing physical address bit 20 to zero whenever an external, asynchronous, active-low mask request is in force and the core runs in real mode. A single masked address leaves the block and feeds both the internal cache lookup and the outgoing read/write bus request, so both paths always see the same wrapped address.

The mask request first passes through a two-flop synchronizer, and a controller then turns it into an effective mask. The controller has three states:
- `ST_STRAP`: reset is active, or the first cycle after reset is released. No masking.
- `ST_LIVE`: the effective mask follows the synchronized request.
- `ST_HOLD`: after an I/O-write target-ready handshake, the value captured at that handshake is held for a fixed window.

The transitions are:
- `STRAP->LIVE` on the first clock with reset inactive.
- `LIVE->HOLD` on a handshake.
- `HOLD->HOLD` while the window counts down. A new handshake restarts the window.
- `HOLD->LIVE` when the window counter reaches zero.
- Any state goes to `STRAP` when reset is asserted.

The same four input pins also serve as configuration straps while reset is asserted. The pins are the mask request, the numeric-error-ignore pin and two local-interrupt pins. The block samples them on every clock during reset and freezes them into a 4-bit ratio code when reset is released. A valid flag then marks the code as usable.

Top module: `addr_wrap_strap`

## Requirements
- R1: `pa_out` equals `pa_in` on every bit except bit 20. Bit 20 is driven low while the effective mask is set and `real_mode` is high.
- R2: While `real_mode` is low, `pa_out` equals `pa_in`, whatever the mask request.
- R3: In `ST_LIVE` with no handshake, a change on `mask_b20_n` reaches `pa_out` bit 20 on the third rising edge after the change. There are two synchronizer stages and one effective-mask register.
- R4: A handshake (`iowr_ack` high at a rising edge) in `ST_LIVE` or `ST_HOLD` captures the synchronizer output present at that edge. That value stays the effective mask for HOLD_CYC further edges, and mask-request changes are ignored until then. A handshake inside the window recaptures and restarts the window.
- R5: While `rst_n` is low, `strap_code` takes the inverted pin values on every edge. Bit 3 comes from `mask_b20_n`, bit 2 from `nerr_ign_n`, and bits 1:0 from `lirq_n[1:0]`.
- R6: Once `rst_n` is high, `strap_code` holds the value sampled at the last edge with reset low. Later changes on the four pins do not alter it.
- R7: `strap_valid` is low while `rst_n` is low. It is high from the first rising edge at which `rst_n` is high, and stays high until the next reset.
- R8: While `rst_n` is low, no masking is applied: `pa_out` equals `pa_in` even with the mask request asserted and `real_mode` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset; also the strap sampling window |
| pa_in | input | 33 | Physical address bits 35:3 before wrap |
| real_mode | input | 1 | High while the core runs in real mode |
| mask_b20_n | input | 1 | Asynchronous active-low bit-20 mask request; strap bit 3 during reset |
| nerr_ign_n | input | 1 | Active-low numeric-error-ignore pin; strap bit 2 during reset |
| lirq_n | input | 2 | Active-low local interrupt pins; strap bits 1:0 during reset |
| iowr_ack | input | 1 | Target-ready handshake of an I/O write |
| pa_out | output | 33 | Physical address bits 35:3 after wrap, for cache lookup and bus request |
| strap_code | output | 4 | Frozen clock-ratio strap code |
| strap_valid | output | 1 | High once the strap code is frozen |

## Verification
The I/O-write handshake and a transition of the mask request can land in the same cycle. The question then is whether the handshake captures the old or the new request value. The bench provokes this by flipping the mask pin in the same cycle that the handshake is sampled, and again in the cycle right after it. In both cases the old value is still in the synchronizer, so the captured mask must be the old one. It must also hold for exactly the window length, and the new value must appear one edge after the window closes. A handshake that arrives again inside the window is also checked: it must stretch the window, and the bench counts edges to confirm by how much.

// File: rtl/addr_wrap_pkg.sv
package addr_wrap_pkg;

    typedef enum logic [1:0] {
        ST_STRAP = 2'd0,
        ST_LIVE  = 2'd1,
        ST_HOLD  = 2'd2
    } wrap_st_e;

    localparam int STRAP_W = 4;

endpackage

// File: rtl/mask_sync.sv
module mask_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/strap_freeze.sv
module strap_freeze
    import addr_wrap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] pins_act,
    output logic [STRAP_W-1:0] code,
    output logic               valid
);
    // Code register samples during reset and holds afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) code <= pins_act;
    end

    always_ff @(posedge clk) begin
        valid <= rst_n;
    end

    // R5: code tracks the inverted pins every reset cycle
    p_track_in_reset_r5: assert property (@(posedge clk)
        !rst_n |=> (code == $past(pins_act)));

    // R6: frozen code never moves outside reset
    p_code_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(code));

    // R7: valid rises one edge after release and stays
    p_valid_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> valid);

    p_valid_low_r7: assert property (@(posedge clk)
        !rst_n |=> !valid);

endmodule

// File: rtl/wrap_ctrl.sv
module wrap_ctrl
    import addr_wrap_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mask_sync,
    input  logic iowr_ack,
    output logic mask_eff
);
    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(HOLD_CYC - 1);

    wrap_st_e      st, st_n;
    logic [CW-1:0] cnt, cnt_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_STRAP;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // next state
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            ST_STRAP: begin
                st_n = ST_LIVE;
            end
            ST_LIVE: begin
                if (iowr_ack) begin
                    st_n  = ST_HOLD;
                    cnt_n = CNT_LOAD;
                end
            end
            ST_HOLD: begin
                if (iowr_ack) begin
                    cnt_n = CNT_LOAD;
                end else if (cnt == '0) begin
                    st_n = ST_LIVE;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            default: begin
                st_n  = ST_STRAP;
                cnt_n = '0;
            end
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_eff <= 1'b0;
        end else begin
            unique case (st)
                ST_STRAP: mask_eff <= 1'b0;
                ST_LIVE:  mask_eff <= mask_sync;
                ST_HOLD:  if (iowr_ack) mask_eff <= mask_sync;
                default:  mask_eff <= 1'b0;
            endcase
        end
    end

    // R3: in live tracking the mask follows the synchronizer one edge later
    p_live_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(st) == ST_LIVE) |-> (mask_eff == $past(mask_sync)));

    // R4: inside the hold window the mask does not move without a new handshake
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(st) == ST_HOLD && !$past(iowr_ack)) |-> $stable(mask_eff));

    // R4: a handshake always lands in the hold state
    p_ack_enters_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iowr_ack && st != ST_STRAP) |=> (st == ST_HOLD));

    // R8: reset clears the effective mask
    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> !mask_eff);

endmodule

// File: rtl/addr_wrap_strap.sv
module addr_wrap_strap
    import addr_wrap_pkg::*;
#(
    parameter int PA_MSB      = 35,
    parameter int PA_LSB      = 3,
    parameter int WRAP_BIT    = 20,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PA_MSB:PA_LSB] pa_in,
    input  logic                 real_mode,
    input  logic                 mask_b20_n,
    input  logic                 nerr_ign_n,
    input  logic [1:0]           lirq_n,
    input  logic                 iowr_ack,
    output logic [PA_MSB:PA_LSB] pa_out,
    output logic [STRAP_W-1:0]   strap_code,
    output logic                 strap_valid
);
    localparam int PA_W = PA_MSB - PA_LSB + 1;
    localparam logic [PA_MSB:PA_LSB] WRAP_ONEHOT = PA_W'(1) << (WRAP_BIT - PA_LSB);

    logic               mask_sync_q;
    logic               mask_eff;
    logic [STRAP_W-1:0] pins_act;

    assign pins_act = {~mask_b20_n, ~nerr_ign_n, ~lirq_n};

    mask_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (~mask_b20_n),
        .q     (mask_sync_q)
    );

    wrap_ctrl #(.HOLD_CYC(HOLD_CYC)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_sync (mask_sync_q),
        .iowr_ack  (iowr_ack),
        .mask_eff  (mask_eff)
    );

    strap_freeze u_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_act (pins_act),
        .code     (strap_code),
        .valid    (strap_valid)
    );

    // single masked address feeds cache lookup and bus request alike
    generate
        for (genvar i = PA_LSB; i <= PA_MSB; i++) begin : g_bit
            if (i == WRAP_BIT) begin : g_wrap
                assign pa_out[i] = pa_in[i] & ~(mask_eff & real_mode);
            end else begin : g_pass
                assign pa_out[i] = pa_in[i];
            end
        end
    endgenerate

    // R1: only the wrap bit may differ from the input
    p_keep_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((pa_out | WRAP_ONEHOT) == (pa_in | WRAP_ONEHOT)));

    // R1: the wrap bit can only be cleared, never set
    p_no_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_out[WRAP_BIT] |-> pa_in[WRAP_BIT]));

    // R2: outside real mode the address passes untouched
    p_real_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !real_mode |-> (pa_out == pa_in));

endmodule

// File: tb/tb_addr_wrap_strap.sv
module tb_addr_wrap_strap;

    localparam int HOLD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [35:3] pa_in = '0;
    logic        real_mode = 1'b0;
    logic        mask_b20_n = 1'b1;
    logic        nerr_ign_n = 1'b1;
    logic [1:0]  lirq_n = 2'b11;
    logic        iowr_ack = 1'b0;
    logic [35:3] pa_out;
    logic [3:0]  strap_code;
    logic        strap_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    addr_wrap_strap #(.HOLD_CYC(HOLD)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pa_in       (pa_in),
        .real_mode   (real_mode),
        .mask_b20_n  (mask_b20_n),
        .nerr_ign_n  (nerr_ign_n),
        .lirq_n      (lirq_n),
        .iowr_ack    (iowr_ack),
        .pa_out      (pa_out),
        .strap_code  (strap_code),
        .strap_valid (strap_valid)
    );

    always #2 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:3] wrapped(input logic [35:3] a, input bit m);
        logic [35:3] r;
        r = a;
        if (m) r[20] = 1'b0;
        return r;
    endfunction

    task automatic set_pins(input logic [3:0] v);
        {mask_b20_n, nerr_ign_n, lirq_n} = ~v;
    endtask

    // expects pa_in bit 20 set and real_mode high
    task automatic chk_mask(input string req, input bit m);
        chk(req, 64'(pa_out), 64'(wrapped(pa_in, m)));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // reset state
        real_mode = 1'b1;
        pa_in = '1;
        set_pins(4'hF);
        tick();
        chk("R7 reset valid", 64'(strap_valid), 64'd0);
        chk("R8 no mask in reset", 64'(pa_out), 64'(pa_in));

        // strap sweep: all 16 codes, each then disturbed by all 16 pin patterns
        for (int c = 0; c < 16; c++) begin
            rst_n = 1'b0;
            set_pins(4'(c) ^ 4'hA);
            tick();
            chk("R5 tracks in reset", 64'(strap_code), 64'(4'(c) ^ 4'hA));
            chk("R7 low in reset", 64'(strap_valid), 64'd0);
            chk("R8 no mask in reset", 64'(pa_out), 64'(pa_in));
            set_pins(4'(c));
            tick();
            chk("R5 tracks in reset", 64'(strap_code), 64'(c));
            rst_n = 1'b1;
            #0.5;
            chk("R7 not yet valid", 64'(strap_valid), 64'd0);
            tick();
            chk("R7 valid after release", 64'(strap_valid), 64'd1);
            chk("R6 frozen at release", 64'(strap_code), 64'(c));
            for (int p = 0; p < 16; p++) begin
                set_pins(4'(p));
                tick();
                chk("R6 pins ignored", 64'(strap_code), 64'(c));
                chk("R7 stays valid", 64'(strap_valid), 64'd1);
            end
        end

        // back to normal use, mask pin inactive
        set_pins(4'h0);
        repeat (4) tick();

        // mapping sweep over mask, mode and address patterns
        for (int m = 0; m < 2; m++) begin
            mask_b20_n = ~m[0];
            repeat (4) tick();
            for (int rm = 0; rm < 2; rm++) begin
                for (int k = 0; k < 24; k++) begin
                    logic [35:3] a;
                    a = 33'(((64'(k) + 64'd1) * 64'h9E3779B97F4A7C15) >> 11);
                    a[20] = k[0];
                    pa_in = a;
                    real_mode = rm[0];
                    #0.5;
                    if (rm == 0)
                        chk("R2 pass outside real mode", 64'(pa_out), 64'(a));
                    else
                        chk("R1 wrap in real mode", 64'(pa_out), 64'(wrapped(a, m[0])));
                end
            end
        end

        // latency through synchronizer and register
        real_mode = 1'b1;
        pa_in = '1;
        mask_b20_n = 1'b1;
        repeat (6) tick();
        mask_b20_n = 1'b0;
        tick(); chk_mask("R3 edge1", 1'b0);
        tick(); chk_mask("R3 edge2", 1'b0);
        tick(); chk_mask("R3 edge3", 1'b1);
        mask_b20_n = 1'b1;
        tick(); chk_mask("R3 release edge1", 1'b1);
        tick(); chk_mask("R3 release edge2", 1'b1);
        tick(); chk_mask("R3 release edge3", 1'b0);

        // hold: pin flips right after the handshake
        mask_b20_n = 1'b0;
        repeat (6) tick();
        iowr_ack = 1'b1;
        tick();
        iowr_ack = 1'b0;
        mask_b20_n = 1'b1;
        for (int i = 0; i < HOLD; i++) begin
            tick(); chk_mask("R4 held after flip", 1'b1);
        end
        tick(); chk_mask("R4 window closed", 1'b0);

        // hold: pin flips in the same cycle as the handshake
        mask_b20_n = 1'b0;
        repeat (6) tick();
        iowr_ack = 1'b1;
        mask_b20_n = 1'b1;
        tick();
        iowr_ack = 1'b0;
        for (int i = 0; i < HOLD; i++) begin
            tick(); chk_mask("R4 same-cycle capture old", 1'b1);
        end
        tick(); chk_mask("R4 same-cycle window closed", 1'b0);

        // hold: retrigger inside the window
        mask_b20_n = 1'b0;
        repeat (6) tick();
        iowr_ack = 1'b1;
        tick();
        iowr_ack = 1'b0;
        mask_b20_n = 1'b1;
        tick(); chk_mask("R4 retrigger first window", 1'b1);
        iowr_ack = 1'b1;
        tick(); chk_mask("R4 retrigger recapture", 1'b1);
        iowr_ack = 1'b0;
        for (int i = 0; i < HOLD; i++) begin
            tick(); chk_mask("R4 retrigger held", 1'b1);
        end
        tick(); chk_mask("R4 retrigger closed", 1'b0);

        // outside real mode a held mask still has no effect
        mask_b20_n = 1'b0;
        repeat (6) tick();
        real_mode = 1'b0;
        #0.5;
        chk("R2 held mask ignored outside real mode", 64'(pa_out), 64'(pa_in));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule